// File: doc/BRIEF.md
# Double-Buffered Color Palette Lookup

This block keeps four independent color palettes for a display pipeline. Every palette has 256 entries of 24-bit color (8 bits each of red, green and blue) and is built as a ping-pong pair of banks. At any time one bank feeds the pixel lookup of the display planes and the other bank is the one the CPU writes and reads. Software fills the CPU-side bank while the display keeps showing the other one undisturbed.

To publish a freshly loaded palette, software sets that palette's arm bit. The banks of every armed palette trade roles together at the next vertical-sync falling edge, or when the display-reset input is released (goes from 1 to 0), whichever comes first. The arm bit then reads back as 0, so software can poll it before starting the next update. Each display plane carries a 2-bit palette select and an 8-bit pixel index and receives the registered color one cycle later.

Top module: `palette_lut`

## Requirements
- R1: A CPU write with `cpu_we` high stores `cpu_wdata` in the CPU-side bank of the palette addressed by `cpu_waddr`, where bits [9:8] hold the palette number and bits [7:0] the entry index.
- R2: `cpu_raddr` uses the same encoding as `cpu_waddr`; `cpu_rdata` shows the CPU-side bank entry one clock after the address is presented, so after a swap it returns the other bank's contents.
- R3: For plane k, select is `plane_sel[2k+1:2k]`, index is `plane_idx[8k+7:8k]` and the color appears on `plane_color[24k+23:24k]` one clock later, read from the display-side bank of the selected palette.
- R4: `arm_we` high with bit p of `arm_mask` set marks palette p as pending; mask bits that are 0 leave their palette unchanged; `arm_status` bit p shows palette p pending.
- R5: A clock in which `vsync` is 0 after being sampled 1 on the previous clock is a swap event; a rising or steady `vsync` never swaps.
- R6: A clock in which `disp_rst` is 0 after being sampled 1 on the previous clock is a swap event; out of reset the previous sample counts as 1, so palettes armed before release swap on that release.
- R7: A swap event exchanges the banks of every pending palette only and clears their pending bits; arming an already pending palette has no further effect.
- R8: All pending palettes exchange banks in the same clock, so every plane sees the new contents from the same cycle on.
- R9: After reset every palette displays bank 0 (CPU side is bank 1), nothing is pending, and `plane_color` and `cpu_rdata` are 0.
- R10: A CPU write in the clock of a swap event lands in the bank that was CPU-side before the swap; an arm in that clock is not consumed by that swap and stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync level |
| disp_rst | input | 1 | Display-reset level, 1 while held in reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_waddr | input | 10 | Write address {palette, index} |
| cpu_wdata | input | 24 | Write color {R, G, B} |
| cpu_raddr | input | 10 | Read address {palette, index} |
| cpu_rdata | output | 24 | Registered CPU-side read data |
| arm_we | input | 1 | Arm strobe |
| arm_mask | input | 4 | Palettes to arm, bit p for palette p |
| arm_status | output | 4 | Pending swap per palette |
| plane_sel | input | 4 | Palette select per plane, 2 bits each |
| plane_idx | input | 16 | Pixel index per plane, 8 bits each |
| plane_color | output | 48 | Registered color per plane, 24 bits each |

## Verification
The bench sweeps every entry of all four palettes through the CPU port and through both planes, with data computed from palette, index and load generation so that a bank or palette mix-up shows a wrong generation or palette field. It arms subsets of palettes, so a design that swapped every palette or none of them, or swapped on a rising `vsync`, would show stale or early colors. It re-arms a pending palette and arms with an empty mask, which a design that toggled rather than set the pending bit would get wrong. It lands a write and a new arm in the very clock of a swap: a design that let the swap see the new arm would clear it, and one that steered the write by the post-swap bank would lose the value from the displayed bank.

// File: rtl/cpal_pkg.sv
package cpal_pkg;

  // A level that was 1 on the previous clock and is 0 now.
  function automatic logic fall_edge(input logic prev_lvl, input logic now_lvl);
    return prev_lvl & ~now_lvl;
  endfunction

  // The CPU always owns the bank the display does not use.
  function automatic logic cpu_bank_of(input logic disp_bank);
    return ~disp_bank;
  endfunction

  // Palette number taken from the top of a {palette, index} address.
  function automatic int unsigned addr_pal(input logic [15:0] addr, input int unsigned idx_w);
    return int'(addr >> idx_w);
  endfunction

endpackage

// File: rtl/cpal_swap_ctrl.sv
module cpal_swap_ctrl #(
  parameter int NUM_PAL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vsync,
  input  logic               disp_rst,
  input  logic               arm_we,
  input  logic [NUM_PAL-1:0] arm_mask,
  output logic [NUM_PAL-1:0] pending,
  output logic [NUM_PAL-1:0] disp_bank,
  output logic               swap_evt
);
  import cpal_pkg::*;

  logic vs_q;
  logic dr_q;
  logic vs_fall;
  logic dr_release;
  logic [NUM_PAL-1:0] arm_hit;
  logic [NUM_PAL-1:0] pending_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
      dr_q <= 1'b1;   // the unit leaves reset in display reset
    end else begin
      vs_q <= vsync;
      dr_q <= disp_rst;
    end
  end

  assign vs_fall    = fall_edge(vs_q, vsync);
  assign dr_release = fall_edge(dr_q, disp_rst);
  assign swap_evt   = vs_fall | dr_release;
  assign arm_hit    = arm_we ? arm_mask : '0;

  always_comb begin
    pending_nx = swap_evt ? '0 : pending;
    pending_nx = pending_nx | arm_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= '0;
      disp_bank <= '0;
    end else begin
      pending <= pending_nx;
      if (swap_evt) disp_bank <= disp_bank ^ pending;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PAL; p++) begin : g_chk
      assert_armed_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_evt && pending[p]) |=> (disp_bank[p] != $past(disp_bank[p])));
      assert_unarmed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_evt || !pending[p]) |=> $stable(disp_bank[p]));
      assert_pending_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_evt && !arm_hit[p]) |=> !pending[p]);
      assert_arm_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_hit[p] |=> pending[p]);
      assert_hold_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_evt && pending[p]) |=> pending[p]);
    end
  endgenerate

  assert_rise_no_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync) && !dr_release) |=> $stable(disp_bank));

endmodule

// File: rtl/cpal_store.sv
module cpal_store #(
  parameter int IDX_W      = 8,
  parameter int COLOR_W    = 24,
  parameter int NUM_PLANES = 2
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic                        wr_bank,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [COLOR_W-1:0]          wr_data,
  input  logic                        rd_bank,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [COLOR_W-1:0]          rd_entry,
  input  logic                        disp_bank,
  input  logic [NUM_PLANES*IDX_W-1:0] plane_idx,
  output logic [NUM_PLANES*COLOR_W-1:0] disp_entry
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COLOR_W-1:0] mem [2][DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_bank][wr_idx] <= wr_data;
  end

  assign rd_entry = mem[rd_bank][rd_idx];

  generate
    for (genvar k = 0; k < NUM_PLANES; k++) begin : g_plane
      assign disp_entry[k*COLOR_W +: COLOR_W] = mem[disp_bank][plane_idx[k*IDX_W +: IDX_W]];
    end
  endgenerate

endmodule

// File: rtl/cpal_out_mux.sv
module cpal_out_mux #(
  parameter int NUM_PAL    = 4,
  parameter int NUM_PLANES = 2,
  parameter int COLOR_W    = 24,
  parameter int SEL_W      = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_PAL*NUM_PLANES*COLOR_W-1:0] disp_entries,
  input  logic [NUM_PLANES*SEL_W-1:0]         plane_sel,
  output logic [NUM_PLANES*COLOR_W-1:0]       plane_color,
  input  logic [NUM_PAL*COLOR_W-1:0]          cpu_entries,
  input  logic [SEL_W-1:0]                    cpu_sel,
  output logic [COLOR_W-1:0]                  cpu_rdata
);
  logic [NUM_PLANES*COLOR_W-1:0] plane_nx;
  logic [COLOR_W-1:0]            cpu_nx;

  always_comb begin
    plane_nx = '0;
    for (int k = 0; k < NUM_PLANES; k++) begin
      for (int p = 0; p < NUM_PAL; p++) begin
        if (plane_sel[k*SEL_W +: SEL_W] == SEL_W'(p))
          plane_nx[k*COLOR_W +: COLOR_W] = disp_entries[(p*NUM_PLANES+k)*COLOR_W +: COLOR_W];
      end
    end
  end

  always_comb begin
    cpu_nx = '0;
    for (int p = 0; p < NUM_PAL; p++) begin
      if (cpu_sel == SEL_W'(p)) cpu_nx = cpu_entries[p*COLOR_W +: COLOR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plane_color <= '0;
      cpu_rdata   <= '0;
    end else begin
      plane_color <= plane_nx;
      cpu_rdata   <= cpu_nx;
    end
  end

  assert_reset_clear_R9: assert property (@(posedge clk)
    $fell(rst_n) |=> (plane_color == '0 && cpu_rdata == '0));

endmodule

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int NUM_PAL    = 4,
  parameter int IDX_W      = 8,
  parameter int COLOR_W    = 24,
  parameter int NUM_PLANES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            vsync,
  input  logic                            disp_rst,
  input  logic                            cpu_we,
  input  logic [$clog2(NUM_PAL)+IDX_W-1:0] cpu_waddr,
  input  logic [COLOR_W-1:0]              cpu_wdata,
  input  logic [$clog2(NUM_PAL)+IDX_W-1:0] cpu_raddr,
  output logic [COLOR_W-1:0]              cpu_rdata,
  input  logic                            arm_we,
  input  logic [NUM_PAL-1:0]              arm_mask,
  output logic [NUM_PAL-1:0]              arm_status,
  input  logic [NUM_PLANES*$clog2(NUM_PAL)-1:0] plane_sel,
  input  logic [NUM_PLANES*IDX_W-1:0]     plane_idx,
  output logic [NUM_PLANES*COLOR_W-1:0]   plane_color
);
  import cpal_pkg::*;

  localparam int SEL_W  = $clog2(NUM_PAL);
  localparam int ADDR_W = SEL_W + IDX_W;

  logic [NUM_PAL-1:0] disp_bank;
  logic [NUM_PAL-1:0] pending;
  logic               swap_evt;
  logic [SEL_W-1:0]   wr_pal;
  logic [SEL_W-1:0]   rd_pal;
  logic [NUM_PAL-1:0] pal_we;
  logic [NUM_PAL*NUM_PLANES*COLOR_W-1:0] disp_entries;
  logic [NUM_PAL*COLOR_W-1:0]            cpu_entries;

  assign wr_pal     = cpu_waddr[ADDR_W-1:IDX_W];
  assign rd_pal     = cpu_raddr[ADDR_W-1:IDX_W];
  assign arm_status = pending;

  cpal_swap_ctrl #(.NUM_PAL(NUM_PAL)) u_swap (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .disp_rst(disp_rst),
    .arm_we(arm_we), .arm_mask(arm_mask),
    .pending(pending), .disp_bank(disp_bank), .swap_evt(swap_evt)
  );

  generate
    for (genvar p = 0; p < NUM_PAL; p++) begin : g_pal
      assign pal_we[p] = cpu_we && (wr_pal == SEL_W'(p));

      cpal_store #(.IDX_W(IDX_W), .COLOR_W(COLOR_W), .NUM_PLANES(NUM_PLANES)) u_store (
        .clk(clk),
        .we(pal_we[p]),
        .wr_bank(cpu_bank_of(disp_bank[p])),
        .wr_idx(cpu_waddr[IDX_W-1:0]),
        .wr_data(cpu_wdata),
        .rd_bank(cpu_bank_of(disp_bank[p])),
        .rd_idx(cpu_raddr[IDX_W-1:0]),
        .rd_entry(cpu_entries[p*COLOR_W +: COLOR_W]),
        .disp_bank(disp_bank[p]),
        .plane_idx(plane_idx),
        .disp_entry(disp_entries[p*NUM_PLANES*COLOR_W +: NUM_PLANES*COLOR_W])
      );
    end
  endgenerate

  cpal_out_mux #(.NUM_PAL(NUM_PAL), .NUM_PLANES(NUM_PLANES), .COLOR_W(COLOR_W), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .disp_entries(disp_entries), .plane_sel(plane_sel), .plane_color(plane_color),
    .cpu_entries(cpu_entries), .cpu_sel(rd_pal), .cpu_rdata(cpu_rdata)
  );

  assert_write_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pal_we));
  assert_common_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> ($past(pending) == ($past(disp_bank) ^ disp_bank)));

endmodule

// File: tb/palette_lut_bench.sv
module palette_lut_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic disp_rst = 1'b1;
  logic cpu_we = 1'b0;
  logic [9:0] cpu_waddr = '0;
  logic [23:0] cpu_wdata = '0;
  logic [9:0] cpu_raddr = '0;
  logic [23:0] cpu_rdata;
  logic arm_we = 1'b0;
  logic [3:0] arm_mask = '0;
  logic [3:0] arm_status;
  logic [3:0] plane_sel = '0;
  logic [15:0] plane_idx = '0;
  logic [47:0] plane_color;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_lut u_palette_lut (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .disp_rst(disp_rst),
    .cpu_we(cpu_we), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
    .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
    .arm_we(arm_we), .arm_mask(arm_mask), .arm_status(arm_status),
    .plane_sel(plane_sel), .plane_idx(plane_idx), .plane_color(plane_color)
  );

  // Color content for a given load generation, palette and index.
  function automatic logic [23:0] pat(input int gen, input int pal, input int idx);
    logic [7:0] i8;
    i8 = 8'(idx);
    return {4'(gen), 4'(pal), i8, i8 ^ 8'hA5};
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int pal, input int idx, input logic [23:0] d);
    cpu_we = 1'b1; cpu_waddr = {2'(pal), 8'(idx)}; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input int pal, input int idx, input logic [23:0] exp);
    cpu_raddr = {2'(pal), 8'(idx)};
    @(negedge clk);
    check(req, {24'h0, cpu_rdata}, {24'h0, exp});
  endtask

  task automatic look(input int p0, input int i0, input int p1, input int i1);
    plane_sel = {2'(p1), 2'(p0)};
    plane_idx = {8'(i1), 8'(i0)};
    @(negedge clk);
  endtask

  task automatic arm(input logic [3:0] m);
    arm_we = 1'b1; arm_mask = m;
    @(negedge clk);
    arm_we = 1'b0; arm_mask = '0;
  endtask

  task automatic vs_pulse();
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    @(negedge clk);
  endtask

  // gen of the displayed bank per palette, tracked by the bench
  int dgen [4];

  task automatic sweep_display(input string req);
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        look(p, i, 3 - p, 255 - i);
        check(req, plane_color, {pat(dgen[3-p], 3-p, 255-i), pat(dgen[p], p, i)});
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 status", {44'h0, arm_status}, 48'h0);
    check("R9 plane_color", plane_color, 48'h0);
    check("R9 cpu_rdata", {24'h0, cpu_rdata}, 48'h0);

    // R1/R2: load generation 1 into CPU side (bank 1) while in display reset
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 256; i++) wr(p, i, pat(1, p, i));
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 256; i++) rd_check("R1 R2 readback", p, i, pat(1, p, i));

    // R4: arm all
    arm(4'b1111);
    check("R4 armed", {44'h0, arm_status}, {44'h0, 4'b1111});
    @(negedge clk);
    check("R4 stays armed during reset", {44'h0, arm_status}, {44'h0, 4'b1111});

    // R6: release display reset swaps all
    disp_rst = 1'b0;
    @(negedge clk);
    check("R6 cleared on release", {44'h0, arm_status}, 48'h0);
    for (int p = 0; p < 4; p++) dgen[p] = 1;
    sweep_display("R3 R8 display after release");

    // gen 2 into the now CPU-side bank 0
    for (int p = 0; p < 4; p++)
      for (int i = 0; i < 256; i++) wr(p, i, pat(2, p, i));
    for (int p = 0; p < 4; p++)
      rd_check("R2 new CPU bank", p, 17 * p, pat(2, p, 17 * p));

    // R5: arm 0 and 2; a rise alone must not swap
    arm(4'b0101);
    vsync = 1'b1;
    @(negedge clk);
    check("R5 no swap on rise status", {44'h0, arm_status}, {44'h0, 4'b0101});
    look(0, 5, 2, 6);
    check("R5 no swap on rise display", plane_color, {pat(1, 2, 6), pat(1, 0, 5)});
    vsync = 1'b0;
    @(negedge clk);
    check("R5 cleared after fall", {44'h0, arm_status}, 48'h0);
    dgen[0] = 2; dgen[2] = 2;
    sweep_display("R7 only armed palettes swapped");
    rd_check("R2 CPU side after swap p0", 0, 9, pat(1, 0, 9));
    rd_check("R2 CPU side unswapped p1", 1, 9, pat(2, 1, 9));

    // R7: re-arm pending palette and empty mask
    arm(4'b0010);
    arm(4'b0010);
    arm(4'b0000);
    check("R7 rearm no effect", {44'h0, arm_status}, {44'h0, 4'b0010});
    vs_pulse();
    check("R7 pending cleared", {44'h0, arm_status}, 48'h0);
    dgen[1] = 2;
    look(1, 200, 3, 200);
    check("R7 p1 swapped p3 held", plane_color, {pat(1, 3, 200), pat(2, 1, 200)});

    // R10: write and arm in the swap clock
    arm(4'b1000);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    cpu_we = 1'b1; cpu_waddr = {2'd3, 8'd7}; cpu_wdata = 24'hABCDEF;
    arm_we = 1'b1; arm_mask = 4'b0100;
    @(negedge clk);
    cpu_we = 1'b0; arm_we = 1'b0; arm_mask = '0;
    check("R10 new arm kept", {44'h0, arm_status}, {44'h0, 4'b0100});
    dgen[3] = 2;
    look(3, 7, 3, 8);
    check("R10 write hit pre-swap CPU bank", plane_color, {pat(2, 3, 8), 24'hABCDEF});

    // R6 again: reassert then release display reset
    disp_rst = 1'b1;
    @(negedge clk);
    check("R6 no swap on assert", {44'h0, arm_status}, {44'h0, 4'b0100});
    disp_rst = 1'b0;
    @(negedge clk);
    check("R6 second release", {44'h0, arm_status}, 48'h0);
    dgen[2] = 1;
    look(2, 99, 0, 99);
    check("R6 p2 back to gen1", plane_color, {pat(2, 0, 99), pat(1, 2, 99)});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule